// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

The block collects level-sensitive interrupt lines in groups of 32 per bank, with one or two banks set by a build parameter. Each bank keeps a mask register that software can read. Two write-only ports change that mask without a read-modify-write: one sets mask bits and one clears them. The block computes the unmasked active sources of every bank and drives one combined interrupt line toward a parent controller.

Software handles an interrupt by polling the pending word of each bank and skipping banks that read zero. It services the highest set bit first, then changes the mask through the set and clear ports. Input lines pass through a two-flop synchronizer before they appear in the bank status.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1, `irq_o` is 0 and `rdata_o` is 0.
- R2: A change on a source line appears in the status word (word offset 0x00 of its bank) and in `irq_o` after exactly two rising clock edges.
- R3: A write to offset 0x08 sets the mask bit for every 1 in the written word and leaves the bits that are written 0 unchanged. The mask changes only through bus writes.
- R4: A write to offset 0x0C clears the mask bit for every 1 in the written word and leaves the bits that are written 0 unchanged.
- R5: The mask reads back at offset 0x04. Reads of the set port (0x08) and the clear port (0x0C) return zero.
- R6: The pending word at offset 0x10 equals status AND NOT mask. It is level based: when a source line drops, its pending bit clears with no latching.
- R7: `irq_o` is the OR of all pending bits across all banks. A mask write changes `irq_o` in the cycle after the write's clock edge.
- R8: Bank i occupies byte addresses i*0x20 to i*0x20+0x1F, and bank 1 holds sources 32 to 63. Each bank's registers act independently of the other bank.
- R9: Several kinds of access read zero and have no effect when written: a bank index at or above NUM_BANKS, word offsets 0x14 to 0x1C, and any address whose low two bits are not zero.
- R10: A read request (`req_i`=1, `we_i`=0) loads `rdata_o` at the next rising edge. `rdata_o` holds its value in every other cycle, including write cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_BANKS*32 | Level-sensitive interrupt source lines, active high |
| req_i | input | 1 | Bus access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt toward the parent controller |

## Verification
The assertions check several rules on every cycle:
- the mask moves only on bus writes, and a write to the bank-0 set or clear port leaves exactly the written ones set or cleared;
- `rdata_o` holds outside read cycles;
- `irq_o` never rises without a source that was active two edges earlier, and never rises while every bit is masked.

Other behaviour can only be shown by the bench's scenarios. These are the exact two-edge synchronizer latency, the pending value as status AND NOT mask, and the release of pending bits when sources drop. They also cover the independence of the second bank and the silent handling of misaligned, unused and out-of-range addresses.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int unsigned BANK_SRC = 32;
  localparam int unsigned BANK_STRIDE_LOG2 = 5;

  typedef enum logic [2:0] {
    REG_STATUS = 3'd0,
    REG_MASK   = 3'd1,
    REG_SETM   = 3'd2,
    REG_CLRM   = 3'd3,
    REG_PEND   = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/lic_sync.sv
module lic_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lic_decode.sv
module lic_decode
  import lic_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned BIDX_W   = ADDR_W - BANK_STRIDE_LOG2
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [BIDX_W-1:0] bank_o,
  output reg_sel_e          sel_o
);
  logic [2:0] word;
  logic       bank_ok, word_ok, align_ok;

  assign bank_o   = addr_i[ADDR_W-1:BANK_STRIDE_LOG2];
  assign word     = addr_i[BANK_STRIDE_LOG2-1:2];
  assign align_ok = (addr_i[1:0] == 2'b00);
  assign bank_ok  = (int'(bank_o) < int'(NUM_BANKS));
  assign word_ok  = (word <= 3'd4);
  assign hit_o    = req_i && align_ok && bank_ok && word_ok;
  assign sel_o    = reg_sel_e'(word);
endmodule

// File: rtl/lic_bank.sv
module lic_bank #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] status_i,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] mask_o,
  output logic [WIDTH-1:0] pend_o
);
  logic [WIDTH-1:0] mask_q, mask_d;

  // set takes priority over clear on the same bit
  assign mask_d = (mask_q & ~clr_i) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '1;
    else         mask_q <= mask_d;
  end

  assign mask_o = mask_q;
  assign pend_o = status_i & ~mask_q;
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lic_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SRC_W      = NUM_BANKS * BANK_SRC,
  localparam int unsigned BIDX_W     = ADDR_W - BANK_STRIDE_LOG2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SRC_W-1:0]    src_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BANK_SRC-1:0] wdata_i,
  output logic [BANK_SRC-1:0] rdata_o,
  output logic                irq_o
);
  logic [SRC_W-1:0]    status_all, mask_all, pend_all;
  logic                hit;
  logic [BIDX_W-1:0]   bank_idx;
  reg_sel_e            sel;
  logic [BANK_SRC-1:0] rd_val, rdata_q;

  lic_sync #(.WIDTH(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (src_i),
    .q_o    (status_all)
  );

  lic_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .req_i  (req_i),
    .addr_i (addr_i),
    .hit_o  (hit),
    .bank_o (bank_idx),
    .sel_o  (sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bsel;
    logic [BANK_SRC-1:0] set_v, clr_v;

    assign bsel  = hit && we_i && (bank_idx == BIDX_W'(b));
    assign set_v = (bsel && sel == REG_SETM) ? wdata_i : '0;
    assign clr_v = (bsel && sel == REG_CLRM) ? wdata_i : '0;

    lic_bank #(.WIDTH(BANK_SRC)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .status_i (status_all[b*BANK_SRC +: BANK_SRC]),
      .set_i    (set_v),
      .clr_i    (clr_v),
      .mask_o   (mask_all[b*BANK_SRC +: BANK_SRC]),
      .pend_o   (pend_all[b*BANK_SRC +: BANK_SRC])
    );
  end

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      if (hit && bank_idx == BIDX_W'(b)) begin
        case (sel)
          REG_STATUS: rd_val = status_all[b*BANK_SRC +: BANK_SRC];
          REG_MASK:   rd_val = mask_all[b*BANK_SRC +: BANK_SRC];
          REG_PEND:   rd_val = pend_all[b*BANK_SRC +: BANK_SRC];
          default:    rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |pend_all;
endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned SRC_W    = NUM_BANKS * 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SRC_W-1:0]  src_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              irq_o,
  input logic [SRC_W-1:0]  mask_i
);
  p_irq_needs_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(src_i, 2) != '0));

  p_all_masked_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |-> !irq_o);

  p_mask_only_by_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(mask_i));

  p_set_port_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(8'h08))
      |=> ((mask_i[31:0] & $past(wdata_i)) == $past(wdata_i)));

  p_clr_port_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(8'h0C))
      |=> ((mask_i[31:0] & $past(wdata_i)) == 32'h0));

  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
endmodule

bind lvl_irq_ctrl lic_checker #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .src_i   (src_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .mask_i  (mask_all)
);

// File: tb/tb_lvl_irq_ctrl.sv
module tb_lvl_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] src = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvl_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    rd(8'h04, rv); chk("R1 mask bank0", rv, 32'hffff_ffff);
    rd(8'h24, rv); chk("R1 mask bank1", rv, 32'hffff_ffff);
  endtask

  task automatic t_mask_ports;
    wr(8'h0C, 32'h0000_00f0);
    rd(8'h04, rv); chk("R4 clear-mask", rv, 32'hffff_ff0f);
    wr(8'h08, 32'h0000_0010);
    rd(8'h04, rv); chk("R3 set-mask", rv, 32'hffff_ff1f);
    rd(8'h08, rv); chk("R5 set port reads 0", rv, 32'h0);
    rd(8'h0C, rv); chk("R5 clear port reads 0", rv, 32'h0);
  endtask

  task automatic t_sync;
    src[5] = 1'b1;
    idle(1); chk("R2 irq after 1 edge", {31'b0, irq}, 32'h0);
    idle(1); chk("R2 irq after 2 edges", {31'b0, irq}, 32'h1);
    rd(8'h00, rv); chk("R2 status", rv, 32'h0000_0020);
  endtask

  task automatic t_pending;
    src[4] = 1'b1;
    idle(2);
    rd(8'h00, rv); chk("R6 status", rv, 32'h0000_0030);
    rd(8'h10, rv); chk("R6 pending", rv, 32'h0000_0020);
    src = '0;
    idle(2);
    chk("R6 irq drops", {31'b0, irq}, 32'h0);
    rd(8'h10, rv); chk("R6 pending drops", rv, 32'h0);
  endtask

  task automatic t_mask_timing;
    src[5] = 1'b1;
    idle(2); chk("R7 irq on", {31'b0, irq}, 32'h1);
    wr(8'h08, 32'h0000_0020); chk("R7 masked next cycle", {31'b0, irq}, 32'h0);
    wr(8'h0C, 32'h0000_0020); chk("R7 unmasked next cycle", {31'b0, irq}, 32'h1);
    src = '0;
    idle(2);
  endtask

  task automatic t_bank1;
    src[35] = 1'b1;
    idle(2); chk("R8 bank1 masked", {31'b0, irq}, 32'h0);
    wr(8'h2C, 32'h0000_0008); chk("R8 bank1 irq", {31'b0, irq}, 32'h1);
    rd(8'h30, rv); chk("R8 bank1 pending", rv, 32'h0000_0008);
    rd(8'h10, rv); chk("R8 bank0 pending", rv, 32'h0);
    rd(8'h20, rv); chk("R8 bank1 status", rv, 32'h0000_0008);
    src = '0;
    idle(2);
  endtask

  task automatic t_invalid;
    wr(8'h4C, 32'hffff_ffff);
    wr(8'h0D, 32'hffff_ffff);
    wr(8'h1C, 32'hffff_ffff);
    rd(8'h04, rv); chk("R9 bank0 mask kept", rv, 32'hffff_ff1f);
    rd(8'h24, rv); chk("R9 bank1 mask kept", rv, 32'hffff_fff7);
    rd(8'h44, rv); chk("R9 bank2 reads 0", rv, 32'h0);
    rd(8'h14, rv); chk("R9 unused reads 0", rv, 32'h0);
    rd(8'h05, rv); chk("R9 misaligned reads 0", rv, 32'h0);
  endtask

  task automatic t_rdata_hold;
    rd(8'h04, rv);
    idle(3); chk("R10 hold idle", rdata, 32'hffff_ff1f);
    wr(8'h08, 32'h0); chk("R10 hold on write", rdata, 32'hffff_ff1f);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    t_reset();
    t_mask_ports();
    t_sync();
    t_pending();
    t_mask_timing();
    t_bank1();
    t_invalid();
    t_rdata_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule